// File: doc/BRIEF.md
# Programmable LCD Raster Timing Controller

This block produces the raster timing for a parallel LCD panel: horizontal and vertical sync, a data-enable strobe and the coordinates of the active pixel. A host programs its timing through a small set of 32-bit registers. The counters move one step per pixel clock enable and run only while the external enable input, the master enable bit and the channel enable bit are all set. Each sync output has its own polarity bit.

Two interrupt sources share one interrupt line. A vertical-blank flag sets when the last active line of a frame has been scanned. A line flag sets when the scan reaches a programmed line. Each source has its own enable bit. A flag stays set until the host writes it back as 0. Timing fields are stored minus one. The back porch counts from the start of the sync pulse, so it includes the sync width. The vertical total is written as twice the line count. The active area can be pushed down by a start delay of up to 30 lines.

Top module: `lcd_tc`

## Requirements
- R1: The pixel and line counters hold at 0 unless `en_i`, the master enable (bit 31 at 0x000) and the channel enable (bit 31 at 0x040) are all 1. While running they advance only in cycles where `pclk_en_i` is 1. While stopped, `de_o` is 0 and both syncs sit at their inactive level.
- R2: A line lasts H+1 pixel ticks, where H is bits 31:16 at 0x04C. A frame lasts V/2 lines, where V is bits 31:16 at 0x050.
- R3: The hsync pulse is active on pixels 0 to HS, where HS is bits 31:16 at 0x054. The vsync pulse is active on lines 0 to VS, where VS is bits 15:0 at 0x054.
- R4: At 0x088, bit 25 inverts hsync and bit 24 inverts vsync. With a bit at 0 the pulse is high while active; with it at 1 the pulse is low while active.
- R5: `de_o` is 1 on pixels HB+1 to HB+1+AW and on lines VB+1+D to VB+1+D+AH. Here HB and VB are bits 15:0 at 0x04C and 0x050, AW and AH are bits 31:16 and 15:0 at 0x048, and D is the effective start delay. `pix_x_o` and `line_y_o` give the position inside the active area and are 0 when `de_o` is 0.
- R6: The start delay field (bits 8:4 at 0x040) takes effect as min(field, 30) lines.
- R7: The vertical-blank flag (bit 15 at 0x004) sets on the pixel tick that moves past the last pixel of the last active line. `irq_o` is 1 while this flag and its enable (bit 31 at 0x004) are both 1.
- R8: A write to 0x004 clears each flag whose bit is written 0 and leaves set each flag whose bit is written 1. When a flag set event falls in the same cycle as a clearing write, the flag ends up set.
- R9: The line flag (bit 13 at 0x004, enable bit 29) sets on the tick taken at pixel 0 of line L, where L is bits 11:0 at 0x008. `irq_o` also asserts while this flag and its enable are both 1.
- R10: With the output map select (bit 0 at 0x000) at 1, `de_o` stays 0 and both syncs stay inactive.
- R11: Reads return the stored fields at their bit positions, with all other bits 0. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable |
| pclk_en_i | input | 1 | Pixel clock enable |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_x_o | output | 16 | Active pixel column |
| line_y_o | output | 16 | Active line row |
| irq_o | output | 1 | Interrupt |

## Verification
The bench uses the default field widths: 16-bit timing fields, a 5-bit delay field and a 12-bit line number. It programs a 20-pixel by 12-line raster, which gives a 240-tick frame. In that raster every porch, sync edge, wrap and interrupt event comes up many times within a short run. A second raster of 40 lines with a delay field of 31 brings the cap at 30 lines within reach. Polarity inversion, map select, gated pixel ticks and set-versus-clear collisions are each driven against the same scoreboard model.

// File: rtl/lcd_tc_pkg.sv
package lcd_tc_pkg;
  localparam int ADDR_W  = 12;
  localparam int REG_W   = 32;
  localparam int FLD_W   = 16;
  localparam int DLY_W   = 5;
  localparam int LNUM_W  = 12;
  localparam int DLY_MAX = 30;
  localparam int EXT_W   = FLD_W + 2;

  localparam logic [ADDR_W-1:0] OFS_GLB  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_IRQ  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_LINE = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CHAN = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_SIZE = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_HTIM = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_VTIM = 12'h050;
  localparam logic [ADDR_W-1:0] OFS_SYNC = 12'h054;
  localparam logic [ADDR_W-1:0] OFS_POL  = 12'h088;

  // irq register bit positions
  localparam int B_VB_EN = 31;
  localparam int B_LN_EN = 29;
  localparam int B_VB_FL = 15;
  localparam int B_LN_FL = 13;

  typedef struct packed {
    logic              master_en;
    logic              map_sel;
    logic              chan_en;
    logic [DLY_W-1:0]  dly;
    logic [FLD_W-1:0]  hact_m1;
    logic [FLD_W-1:0]  vact_m1;
    logic [FLD_W-1:0]  htot_m1;
    logic [FLD_W-1:0]  hbp_m1;
    logic [FLD_W-1:0]  vtot_x2;
    logic [FLD_W-1:0]  vbp_m1;
    logic [FLD_W-1:0]  hsw_m1;
    logic [FLD_W-1:0]  vsw_m1;
    logic              inv_h;
    logic              inv_v;
    logic [LNUM_W-1:0] line_num;
  } tc_cfg_t;

  function automatic logic [DLY_W-1:0] cap_dly(input logic [DLY_W-1:0] d);
    return (d > DLY_W'(DLY_MAX)) ? DLY_W'(DLY_MAX) : d;
  endfunction

  // first active line index, extended width
  function automatic logic [EXT_W-1:0] v_first(input tc_cfg_t c);
    return EXT_W'(c.vbp_m1) + EXT_W'(1) + EXT_W'(cap_dly(c.dly));
  endfunction
endpackage

// File: rtl/lcd_tc_regs.sv
module lcd_tc_regs
  import lcd_tc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              vb_set_i,
  input  logic              ln_set_i,
  output tc_cfg_t           cfg_o,
  output logic              vb_flag_o,
  output logic              irq_o
);
  tc_cfg_t cfg_q;
  logic vb_en_q, ln_en_q, vb_fl_q, ln_fl_q;
  logic irq_wr;

  assign irq_wr = we_i && (addr_i == OFS_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      vb_en_q <= 1'b0;
      ln_en_q <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        OFS_GLB: begin
          cfg_q.master_en <= wdata_i[31];
          cfg_q.map_sel   <= wdata_i[0];
        end
        OFS_CHAN: begin
          cfg_q.chan_en <= wdata_i[31];
          cfg_q.dly     <= wdata_i[4 +: DLY_W];
        end
        OFS_SIZE: begin
          cfg_q.hact_m1 <= wdata_i[31:16];
          cfg_q.vact_m1 <= wdata_i[15:0];
        end
        OFS_HTIM: begin
          cfg_q.htot_m1 <= wdata_i[31:16];
          cfg_q.hbp_m1  <= wdata_i[15:0];
        end
        OFS_VTIM: begin
          cfg_q.vtot_x2 <= wdata_i[31:16];
          cfg_q.vbp_m1  <= wdata_i[15:0];
        end
        OFS_SYNC: begin
          cfg_q.hsw_m1 <= wdata_i[31:16];
          cfg_q.vsw_m1 <= wdata_i[15:0];
        end
        OFS_POL: begin
          cfg_q.inv_h <= wdata_i[25];
          cfg_q.inv_v <= wdata_i[24];
        end
        OFS_LINE: cfg_q.line_num <= wdata_i[LNUM_W-1:0];
        OFS_IRQ: begin
          vb_en_q <= wdata_i[B_VB_EN];
          ln_en_q <= wdata_i[B_LN_EN];
        end
        default: ;
      endcase
    end
  end

  // set event wins over a clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vb_fl_q <= 1'b0;
      ln_fl_q <= 1'b0;
    end else begin
      vb_fl_q <= (irq_wr ? (vb_fl_q & wdata_i[B_VB_FL]) : vb_fl_q) | vb_set_i;
      ln_fl_q <= (irq_wr ? (ln_fl_q & wdata_i[B_LN_FL]) : ln_fl_q) | ln_set_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_GLB:  rdata_o = {cfg_q.master_en, 30'b0, cfg_q.map_sel};
      OFS_IRQ:  rdata_o = {vb_en_q, 1'b0, ln_en_q, 13'b0, vb_fl_q, 1'b0, ln_fl_q, 13'b0};
      OFS_LINE: rdata_o = {{(REG_W-LNUM_W){1'b0}}, cfg_q.line_num};
      OFS_CHAN: rdata_o = {cfg_q.chan_en, 22'b0, cfg_q.dly, 4'b0};
      OFS_SIZE: rdata_o = {cfg_q.hact_m1, cfg_q.vact_m1};
      OFS_HTIM: rdata_o = {cfg_q.htot_m1, cfg_q.hbp_m1};
      OFS_VTIM: rdata_o = {cfg_q.vtot_x2, cfg_q.vbp_m1};
      OFS_SYNC: rdata_o = {cfg_q.hsw_m1, cfg_q.vsw_m1};
      OFS_POL:  rdata_o = {6'b0, cfg_q.inv_h, cfg_q.inv_v, 24'b0};
      default:  rdata_o = '0;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign vb_flag_o = vb_fl_q;
  assign irq_o     = (vb_fl_q & vb_en_q) | (ln_fl_q & ln_en_q);
endmodule

// File: rtl/lcd_tc_timing.sv
module lcd_tc_timing
  import lcd_tc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tc_cfg_t          cfg_i,
  input  logic             run_i,
  input  logic             pclk_en_i,
  output logic [FLD_W-1:0] hcnt_o,
  output logic [FLD_W-1:0] vcnt_o,
  output logic             tick_o,
  output logic             vb_set_o,
  output logic             ln_set_o
);
  logic [FLD_W-1:0] hcnt_q, vcnt_q, v_last;
  logic [EXT_W-1:0] v_last_act;
  logic             tick, h_wrap;

  assign tick       = run_i & pclk_en_i;
  assign v_last     = (cfg_i.vtot_x2 >> 1) - FLD_W'(1);
  assign v_last_act = v_first(cfg_i) + EXT_W'(cfg_i.vact_m1);
  assign h_wrap     = hcnt_q >= cfg_i.htot_m1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (!run_i) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (tick) begin
      if (h_wrap) begin
        hcnt_q <= '0;
        vcnt_q <= (vcnt_q >= v_last) ? '0 : vcnt_q + FLD_W'(1);
      end else begin
        hcnt_q <= hcnt_q + FLD_W'(1);
      end
    end
  end

  assign vb_set_o = tick && (hcnt_q == cfg_i.htot_m1) && (EXT_W'(vcnt_q) == v_last_act);
  assign ln_set_o = tick && (hcnt_q == '0) && (vcnt_q == FLD_W'(cfg_i.line_num));
  assign hcnt_o   = hcnt_q;
  assign vcnt_o   = vcnt_q;
  assign tick_o   = tick;
endmodule

// File: rtl/lcd_tc_video.sv
module lcd_tc_video
  import lcd_tc_pkg::*;
(
  input  tc_cfg_t          cfg_i,
  input  logic             run_i,
  input  logic [FLD_W-1:0] hcnt_i,
  input  logic [FLD_W-1:0] vcnt_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [FLD_W-1:0] pix_x_o,
  output logic [FLD_W-1:0] line_y_o
);
  localparam int N_SYNC = 2;

  logic                show;
  logic [N_SYNC-1:0]   sync_act, sync_inv, sync_out;
  logic [EXT_W-1:0]    h_lo, h_hi, v_lo, v_hi, hx, vx;
  logic                h_in, v_in;

  assign show = run_i & ~cfg_i.map_sel;

  assign sync_act[0] = hcnt_i <= cfg_i.hsw_m1;
  assign sync_act[1] = vcnt_i <= cfg_i.vsw_m1;
  assign sync_inv[0] = cfg_i.inv_h;
  assign sync_inv[1] = cfg_i.inv_v;

  for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
    assign sync_out[i] = (show & sync_act[i]) ^ sync_inv[i];
  end

  assign hsync_o = sync_out[0];
  assign vsync_o = sync_out[1];

  assign hx   = EXT_W'(hcnt_i);
  assign vx   = EXT_W'(vcnt_i);
  assign h_lo = EXT_W'(cfg_i.hbp_m1) + EXT_W'(1);
  assign h_hi = h_lo + EXT_W'(cfg_i.hact_m1);
  assign v_lo = v_first(cfg_i);
  assign v_hi = v_lo + EXT_W'(cfg_i.vact_m1);
  assign h_in = (hx >= h_lo) && (hx <= h_hi);
  assign v_in = (vx >= v_lo) && (vx <= v_hi);

  assign de_o     = show & h_in & v_in;
  assign pix_x_o  = de_o ? FLD_W'(hx - h_lo) : '0;
  assign line_y_o = de_o ? FLD_W'(vx - v_lo) : '0;
endmodule

// File: rtl/lcd_tc.sv
module lcd_tc
  import lcd_tc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pclk_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [FLD_W-1:0]  pix_x_o,
  output logic [FLD_W-1:0]  line_y_o,
  output logic              irq_o
);
  tc_cfg_t          cfg;
  logic             run, tick, vb_set, ln_set, vb_flag;
  logic [FLD_W-1:0] hcnt, vcnt;

  assign run = en_i & cfg.master_en & cfg.chan_en;

  lcd_tc_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .vb_set_i  (vb_set),
    .ln_set_i  (ln_set),
    .cfg_o     (cfg),
    .vb_flag_o (vb_flag),
    .irq_o     (irq_o)
  );

  lcd_tc_timing u_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .run_i     (run),
    .pclk_en_i (pclk_en_i),
    .hcnt_o    (hcnt),
    .vcnt_o    (vcnt),
    .tick_o    (tick),
    .vb_set_o  (vb_set),
    .ln_set_o  (ln_set)
  );

  lcd_tc_video u_video (
    .cfg_i    (cfg),
    .run_i    (run),
    .hcnt_i   (hcnt),
    .vcnt_i   (vcnt),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .de_o     (de_o),
    .pix_x_o  (pix_x_o),
    .line_y_o (line_y_o)
  );
endmodule

// File: rtl/lcd_tc_chk.sv
module lcd_tc_chk
  import lcd_tc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             tick_i,
  input logic             map_sel_i,
  input logic             de_i,
  input logic [FLD_W-1:0] hcnt_i,
  input logic [FLD_W-1:0] vcnt_i,
  input logic [FLD_W-1:0] htot_m1_i,
  input logic             vb_flag_i,
  input logic             vb_set_i,
  input logic             clr_wr_i
);
  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (hcnt_i == '0 && vcnt_i == '0));

  // R1
  idle_de_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !de_i);

  // R1
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> ($stable(hcnt_i) && $stable(vcnt_i)));

  // R2
  hwrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hcnt_i == htot_m1_i) |=> hcnt_i == '0);

  // R7
  vb_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vb_flag_i) |-> $past(vb_set_i));

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vb_set_i && clr_wr_i) |=> vb_flag_i);

  // R10
  map_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_sel_i |-> !de_i);
endmodule

bind lcd_tc lcd_tc_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run),
  .tick_i    (tick),
  .map_sel_i (cfg.map_sel),
  .de_i      (de_o),
  .hcnt_i    (hcnt),
  .vcnt_i    (vcnt),
  .htot_m1_i (cfg.htot_m1),
  .vb_flag_i (vb_flag),
  .vb_set_i  (vb_set),
  .clr_wr_i  (bus_we_i && (bus_addr_i == 12'h004) && !bus_wdata_i[15])
);

// File: tb/lcd_tc_tb.sv
module lcd_tc_tb;
  import lcd_tc_pkg::*;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic              pclk_en_i = 1'b0;
  logic              bus_we_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [REG_W-1:0]  bus_wdata_i = '0;
  logic [REG_W-1:0]  bus_rdata_o;
  logic              hsync_o, vsync_o, de_o, irq_o;
  logic [FLD_W-1:0]  pix_x_o, line_y_o;

  always #5 clk_i = ~clk_i;

  lcd_tc u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .pclk_en_i(pclk_en_i),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .pix_x_o(pix_x_o), .line_y_o(line_y_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int s_master, s_map, s_chan, s_dly, s_hact, s_vact, s_htot, s_hbp;
  int s_vt2, s_vbp, s_hsw, s_vsw, s_invh, s_invv, s_lnum;
  int s_vbe, s_lne, s_vbf, s_lnf;
  int m_h, m_v;
  int md, mvla, mvlast;
  bit mrun, mtick, mvbs, mlns;

  function automatic int eff_dly();
    return (s_dly > 30) ? 30 : s_dly;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_master = 0; s_map = 0; s_chan = 0; s_dly = 0; s_hact = 0; s_vact = 0;
      s_htot = 0; s_hbp = 0; s_vt2 = 0; s_vbp = 0; s_hsw = 0; s_vsw = 0;
      s_invh = 0; s_invv = 0; s_lnum = 0; s_vbe = 0; s_lne = 0; s_vbf = 0; s_lnf = 0;
      m_h = 0; m_v = 0;
    end else begin
      md     = eff_dly();
      mrun   = en_i && s_master != 0 && s_chan != 0;
      mtick  = mrun && pclk_en_i;
      mvla   = s_vbp + 1 + md + s_vact;
      mvlast = s_vt2 / 2 - 1;
      mvbs   = mtick && m_h == s_htot && m_v == mvla;
      mlns   = mtick && m_h == 0 && m_v == s_lnum;
      if (!mrun) begin
        m_h = 0; m_v = 0;
      end else if (mtick) begin
        if (m_h >= s_htot) begin
          m_h = 0;
          m_v = (m_v >= mvlast) ? 0 : m_v + 1;
        end else m_h = m_h + 1;
      end
      if (bus_we_i && bus_addr_i == OFS_IRQ) begin
        s_vbf = s_vbf & int'(bus_wdata_i[15]);
        s_lnf = s_lnf & int'(bus_wdata_i[13]);
      end
      if (mvbs) s_vbf = 1;
      if (mlns) s_lnf = 1;
      if (bus_we_i) begin
        case (bus_addr_i)
          OFS_GLB:  begin s_master = int'(bus_wdata_i[31]); s_map = int'(bus_wdata_i[0]); end
          OFS_CHAN: begin s_chan = int'(bus_wdata_i[31]); s_dly = int'(bus_wdata_i[8:4]); end
          OFS_SIZE: begin s_hact = int'(bus_wdata_i[31:16]); s_vact = int'(bus_wdata_i[15:0]); end
          OFS_HTIM: begin s_htot = int'(bus_wdata_i[31:16]); s_hbp = int'(bus_wdata_i[15:0]); end
          OFS_VTIM: begin s_vt2 = int'(bus_wdata_i[31:16]); s_vbp = int'(bus_wdata_i[15:0]); end
          OFS_SYNC: begin s_hsw = int'(bus_wdata_i[31:16]); s_vsw = int'(bus_wdata_i[15:0]); end
          OFS_POL:  begin s_invh = int'(bus_wdata_i[25]); s_invv = int'(bus_wdata_i[24]); end
          OFS_LINE: s_lnum = int'(bus_wdata_i[11:0]);
          OFS_IRQ:  begin s_vbe = int'(bus_wdata_i[31]); s_lne = int'(bus_wdata_i[29]); end
          default: ;
        endcase
      end
    end
  end

  typedef struct {
    bit hs, vs, de, irq;
    int x, y;
  } exp_t;

  exp_t sb_q[$];

  // driver side: push expected outputs
  always @(negedge clk_i) begin
    if (rst_ni) begin
      exp_t e;
      bit show, hin, vin;
      int d, hlo, vlo;
      #1;
      d    = eff_dly();
      show = en_i && s_master != 0 && s_chan != 0 && s_map == 0;
      hlo  = s_hbp + 1;
      vlo  = s_vbp + 1 + d;
      hin  = m_h >= hlo && m_h <= hlo + s_hact;
      vin  = m_v >= vlo && m_v <= vlo + s_vact;
      e.hs  = (show && m_h <= s_hsw) ^ (s_invh != 0);
      e.vs  = (show && m_v <= s_vsw) ^ (s_invv != 0);
      e.de  = show && hin && vin;
      e.x   = e.de ? m_h - hlo : 0;
      e.y   = e.de ? m_v - vlo : 0;
      e.irq = (s_vbf != 0 && s_vbe != 0) || (s_lnf != 0 && s_lne != 0);
      sb_q.push_back(e);
    end
  end

  // monitor side: pop and compare
  always @(negedge clk_i) begin
    if (rst_ni) begin
      exp_t e;
      #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(hsync_o == e.hs, "R3/R4", "hsync", hsync_o, e.hs);
        chk(vsync_o == e.vs, "R3/R4", "vsync", vsync_o, e.vs);
        chk(de_o == e.de, "R5", "de", de_o, e.de);
        chk(int'(pix_x_o) == e.x && int'(line_y_o) == e.y, "R5", "x*65536+y",
            int'(pix_x_o) * 65536 + int'(line_y_o), e.x * 65536 + e.y);
        chk(irq_o == e.irq, "R7", "irq", irq_o, e.irq);
      end
    end
  end

  // ---------------- bus tasks (called at a negedge) ----------------
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #3;
    d = bus_rdata_o;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic cfg_a();
    wr(OFS_SIZE, {16'd7, 16'd4});
    wr(OFS_HTIM, {16'd19, 16'd4});
    wr(OFS_VTIM, {16'd24, 16'd1});
    wr(OFS_SYNC, {16'd1, 16'd0});
    wr(OFS_LINE, 32'd3);
    wr(OFS_CHAN, 32'h8000_0000 | (32'd2 << 4));
    wr(OFS_GLB, 32'h8000_0000);
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    int k;
    wait_n(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 R11: reset state
    chk(de_o == 0 && hsync_o == 0 && vsync_o == 0 && irq_o == 0, "R1", "outputs after reset",
        {de_o, hsync_o, vsync_o, irq_o}, 0);
    rd(OFS_HTIM, rv);
    chk(rv == 0, "R11", "reset read", rv, 0);
    @(negedge clk_i);

    cfg_a();
    wr(OFS_IRQ, 32'hA000_0000);
    rd(OFS_HTIM, rv);
    chk(rv == {16'd19, 16'd4}, "R11", "readback 0x04C", rv, {16'd19, 16'd4});
    rd(OFS_CHAN, rv);
    chk(rv == 32'h8000_0020, "R11", "readback 0x040", rv, 32'h8000_0020);
    rd(12'h100, rv);
    chk(rv == 0, "R11", "unmapped read", rv, 0);
    @(negedge clk_i);

    // R2 R3 R5: two frames, free running ticks
    pclk_en_i = 1'b1;
    en_i = 1'b1;
    k = 0;
    for (int i = 0; i < 480; i++) begin
      @(negedge clk_i);
      if (de_o) k++;
    end
    chk(k == 80, "R5", "de count over two frames", k, 80);

    // R1: gated ticks hold the position
    wait_n(1);
    while (!(de_o && pix_x_o == 2)) @(negedge clk_i);
    pclk_en_i = 1'b0;
    wait_n(5);
    chk(pix_x_o == 2 && de_o, "R1", "x hold without tick", pix_x_o, 2);
    // R1: sparse ticks, scoreboard compares
    for (int i = 0; i < 600; i++) begin
      pclk_en_i = (i % 3) != 0;
      @(negedge clk_i);
    end
    pclk_en_i = 1'b1;

    // R1: global enable low stops output
    en_i = 1'b0;
    @(negedge clk_i);
    chk(!de_o && !hsync_o && !vsync_o, "R1", "stopped outputs", {de_o, hsync_o, vsync_o}, 0);
    wr(OFS_IRQ, 32'h2000_0000);
    en_i = 1'b1;
    // R9: line flag after restart at line 3 -> visible at k = 61
    k = 0;
    while (!irq_o && k < 400) begin @(negedge clk_i); k++; end
    chk(k == 61, "R9", "line irq cycle", k, 61);

    en_i = 1'b0;
    wr(OFS_IRQ, 32'h8000_0000);
    en_i = 1'b1;
    // R7: vblank after line 8 pixel 19 -> k = 180
    k = 0;
    while (!irq_o && k < 400) begin @(negedge clk_i); k++; end
    chk(k == 180, "R7", "vblank irq cycle", k, 180);

    // R8: keep / clear semantics with ticks stopped
    wr(OFS_IRQ, 32'hA000_0000);
    wait_n(250);
    pclk_en_i = 1'b0;
    @(negedge clk_i);
    rd(OFS_IRQ, rv);
    chk(rv == 32'hA000_A000, "R8", "both flags set", rv, 32'hA000_A000);
    @(negedge clk_i);
    wr(OFS_IRQ, 32'hA000_8000);
    rd(OFS_IRQ, rv);
    chk(rv == 32'hA000_8000, "R8", "keep vb clear line", rv, 32'hA000_8000);
    chk(irq_o == 1, "R7", "irq with vb flag", irq_o, 1);
    @(negedge clk_i);
    wr(OFS_IRQ, 32'hA000_0000);
    rd(OFS_IRQ, rv);
    chk(rv == 32'hA000_0000, "R8", "all cleared", rv, 32'hA000_0000);
    chk(irq_o == 0, "R8", "irq after clear", irq_o, 0);

    // R8: clearing write on the set cycle
    @(negedge clk_i);
    pclk_en_i = 1'b1;
    @(negedge clk_i);
    while (!(m_h == 19 && m_v == 8)) @(negedge clk_i);
    wr(OFS_IRQ, 32'hA000_0000);
    rd(OFS_IRQ, rv);
    chk(rv[15] == 1'b1, "R8", "set beats clear", rv[15], 1);
    @(negedge clk_i);

    // R4: inverted polarity
    wr(OFS_POL, 32'h0300_0000);
    while (!(m_h == 10 && m_v == 5)) @(negedge clk_i);
    chk(hsync_o && vsync_o, "R4", "inactive inverted", {hsync_o, vsync_o}, 3);
    while (!(m_h == 0 && m_v == 0)) @(negedge clk_i);
    chk(!hsync_o && !vsync_o, "R4", "active inverted", {hsync_o, vsync_o}, 0);
    wait_n(240);
    wr(OFS_POL, 32'h0);

    // R10: map select silences panel output
    wr(OFS_GLB, 32'h8000_0001);
    k = 0;
    for (int i = 0; i < 240; i++) begin
      @(negedge clk_i);
      if (de_o || hsync_o || vsync_o) k++;
    end
    chk(k == 0, "R10", "outputs with map select", k, 0);
    wr(OFS_GLB, 32'h8000_0000);
    wait_n(240);

    // R6: delay field 31 capped to 30
    en_i = 1'b0;
    wr(OFS_VTIM, {16'd80, 16'd1});
    wr(OFS_CHAN, 32'h8000_0000 | (32'd31 << 4));
    en_i = 1'b1;
    k = 0;
    #3;
    while (!de_o && k < 2000) begin @(negedge clk_i); #3; k++; end
    chk(k == 645, "R6", "first active tick with capped delay", k, 645);
    wait_n(900);

    // R2: vertical wrap with 40 lines -> line 0 again after 800 ticks
    en_i = 1'b0;
    @(negedge clk_i);
    en_i = 1'b1;
    wait_n(800);
    chk(m_v == 0 && m_h == 0 && hsync_o && vsync_o, "R2", "frame wrap", {hsync_o, vsync_o}, 3);

    done = 1;
    @(negedge clk_i);
    #5;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule